// File: doc/BRIEF.md
# Configuration Memory Page Programmer

This block is a sequencer that sits above a byte-level two-wire bus engine. It programs and checks a serial configuration EEPROM. A host loads a page-sized internal buffer through a write port and picks an operation and a page number. The block then issues start, byte-send, byte-receive and stop commands to the engine through a request/done handshake. Throughout the operation it holds a serial-enable output high, which puts the memory in programming mode.

There are four operations. A page write sends the page contents and then polls the device until it acknowledges, which shows that its internal write cycle has finished. A page read fills the buffer from the device. The other two operations program and check a four-byte polarity block that sits at fixed addresses above the array. Each operation ends with a one-cycle done pulse and a two-bit result code.

Top module: `cfgmem_page_prog`

## Requirements
- R1: After reset, `ser_en`, `eng_req` and `done` are low, `cmd_ready` is high and `status` is 0.
- R2: A page write (`cmd_op`=0) issues commands in this order: start (`eng_cmd`=0), then three address bytes of page×PAGE_SIZE, high byte first, each as a send-MSB-first command (2), then the PAGE_SIZE buffer bytes in index order as send-LSB-first commands (3), then stop (1).
- R3: After the write's stop, the block repeats polling attempts. Each attempt is start, send-MSB-first of the high address byte, stop. At the stop of the first attempt whose address byte is acknowledged, the block finishes with status 0 (ok).
- R4: If no poll is acknowledged, the block finishes with status 2 (timeout) at the end of the first attempt that completes once the 20 ms timeout (POLL_TIMEOUT_US at CLK_HZ) has elapsed since polling began. It does not finish earlier.
- R5: A page read (`cmd_op`=1) issues start, the three address bytes as in R2, PAGE_SIZE receive commands (4) and stop. `eng_last` is high only on the final receive. Received bytes land in buffer indices 0 upward and are readable at `buf_rd_data`.
- R6: A polarity program (`cmd_op`=2) sends address 0x020000, then buffer bytes 0..3 send-LSB-first, then stop, then polls as in R3.
- R7: A polarity verify (`cmd_op`=3) reads four bytes from 0x020000 and compares them with buffer bytes 0..3. It ends with status 3 (mismatch) if any byte differs and status 0 if all match. The buffer is left unchanged.
- R8: A no-acknowledge or fault reported on a start, address or data command ends the operation: one stop is issued and no further byte is sent, then the block finishes with status 1 (nack). A fault reported on a stop finishes with status 1 directly.
- R9: `ser_en` is high from the cycle after a command is accepted until the operation finishes, and it is high for every engine request. It is low in the cycle `done` pulses.
- R10: `eng_req` stays high, and `eng_cmd`, `eng_tx_byte` and `eng_last` stay stable, until the engine answers with `eng_done`. Each `eng_done` completes exactly one command.
- R11: While an operation runs, `cmd_ready` is low, and both `cmd_valid` and host buffer writes have no effect.
- R12: `done` is a one-cycle pulse. `status` holds its value until the next operation finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Start an operation (taken when cmd_ready) |
| cmd_op | input | 2 | 0 page write, 1 page read, 2 polarity program, 3 polarity verify |
| cmd_page | input | ADDR_W-log2(PAGE_SIZE) | Page number |
| cmd_ready | output | 1 | Idle, a command may be given |
| buf_wr_en | input | 1 | Host buffer write strobe |
| buf_wr_idx | input | log2(PAGE_SIZE) | Host buffer write index |
| buf_wr_data | input | 8 | Host buffer write byte |
| buf_rd_idx | input | log2(PAGE_SIZE) | Host buffer read index |
| buf_rd_data | output | 8 | Buffer byte at buf_rd_idx |
| ser_en | output | 1 | Serial programming-mode enable for the memory |
| eng_req | output | 1 | Command request to the bus engine |
| eng_cmd | output | 3 | 0 start, 1 stop, 2 send MSB-first, 3 send LSB-first, 4 receive |
| eng_tx_byte | output | 8 | Byte to send |
| eng_last | output | 1 | Final receive of a read burst |
| eng_done | input | 1 | Engine finished the current command |
| eng_nack | input | 1 | Sent byte not acknowledged (with eng_done) |
| eng_fault | input | 1 | Bus fault (with eng_done) |
| eng_rx_byte | input | 8 | Received byte (with eng_done) |
| done | output | 1 | Operation finished, one-cycle pulse |
| status | output | 2 | 0 ok, 1 nack, 2 timeout, 3 mismatch |

## Verification
Page writes are run with a device that acknowledges polls at once and with one that refuses several polls. The exact number of repeated attempts shows that polling stops on the first acknowledge. A device that never acknowledges separates a correct timeout, bounded from below and above, from early or endless polling. Page reads with a distinct value per byte, and with an address whose three bytes all differ, expose byte-order, last-flag and buffer-index errors. Polarity reads with matching data and with a single altered byte separate the comparison from a plain read. No-acknowledge and fault injection at a data byte and at the first start checks that the block stops cleanly.

// File: rtl/cfgprog_pkg.sv
package cfgprog_pkg;

   typedef enum logic [1:0] {
      OP_PAGE_WR = 2'd0,
      OP_PAGE_RD = 2'd1,
      OP_POL_WR  = 2'd2,
      OP_POL_RD  = 2'd3
   } op_e;

   typedef enum logic [1:0] {
      ST_OK       = 2'd0,
      ST_NACK     = 2'd1,
      ST_TIMEOUT  = 2'd2,
      ST_MISMATCH = 2'd3
   } status_e;

   typedef enum logic [2:0] {
      ENG_START  = 3'd0,
      ENG_STOP   = 3'd1,
      ENG_TX_MSB = 3'd2,
      ENG_TX_LSB = 3'd3,
      ENG_RX     = 3'd4
   } eng_cmd_e;

   typedef enum logic [3:0] {
      P_IDLE,
      P_START,
      P_ADDR,
      P_DATA,
      P_STOP,
      P_PSTART,
      P_PADDR,
      P_PSTOP,
      P_ASTOP
   } phase_e;

   localparam logic [23:0] POL_BASE   = 24'h02_0000;
   localparam int          POL_BYTES  = 4;
   localparam int          ADDR_BYTES = 3;

endpackage

// File: rtl/cfgprog_page_buf.sv
module cfgprog_page_buf #(
   parameter  int DEPTH = 128,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_we,
   input  logic [IDX_W-1:0] host_widx,
   input  logic [7:0]       host_wdata,
   input  logic             seq_we,
   input  logic [IDX_W-1:0] seq_widx,
   input  logic [7:0]       seq_wdata,
   input  logic [IDX_W-1:0] host_ridx,
   output logic [7:0]       host_rdata,
   input  logic [IDX_W-1:0] seq_ridx,
   output logic [7:0]       seq_rdata
);

   logic [7:0] mem_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < DEPTH; e++) mem_q[e] <= 8'h00;
      end else begin
         for (int e = 0; e < DEPTH; e++) begin
            if (seq_we && seq_widx == IDX_W'(e))
               mem_q[e] <= seq_wdata;
            else if (host_we && host_widx == IDX_W'(e))
               mem_q[e] <= host_wdata;
         end
      end
   end

   assign host_rdata = mem_q[host_ridx];
   assign seq_rdata  = mem_q[seq_ridx];

   // R11
   no_dual_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(seq_we && host_we));

endmodule

// File: rtl/cfgprog_poll_timer.sv
module cfgprog_poll_timer #(
   parameter  int LIMIT = 1_000_000,
   localparam int CW    = $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run)
         cnt_q <= '0;
      else if (cnt_q != CW'(LIMIT))
         cnt_q <= cnt_q + 1'b1;
   end

   assign expired = (cnt_q == CW'(LIMIT));

   // R4
   poll_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && !$past(expired)) |-> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/cfgprog_addr_mux.sv
module cfgprog_addr_mux
   import cfgprog_pkg::*;
#(
   parameter int ADDR_W = 18
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        sel,
   output logic [7:0]        byte_o
);

   localparam int PAD_W = 8 * ADDR_BYTES;

   logic [PAD_W-1:0] padded;
   logic [7:0]       lane [ADDR_BYTES];

   assign padded = PAD_W'(addr);

   for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_lane
      assign lane[b] = padded[8*(ADDR_BYTES-1-b) +: 8];
   end

   always_comb begin
      byte_o = 8'h00;
      for (int b = 0; b < ADDR_BYTES; b++)
         if (sel == 2'(b)) byte_o = lane[b];
   end

endmodule

// File: rtl/cfgmem_page_prog.sv
module cfgmem_page_prog
   import cfgprog_pkg::*;
#(
   parameter  int PAGE_SIZE       = 128,
   parameter  int ADDR_W          = 18,
   parameter  int CLK_HZ          = 50_000_000,
   parameter  int POLL_TIMEOUT_US = 20_000,
   localparam int IDX_W           = $clog2(PAGE_SIZE),
   localparam int PAGE_W          = ADDR_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [PAGE_W-1:0] cmd_page,
   output logic              cmd_ready,
   input  logic              buf_wr_en,
   input  logic [IDX_W-1:0]  buf_wr_idx,
   input  logic [7:0]        buf_wr_data,
   input  logic [IDX_W-1:0]  buf_rd_idx,
   output logic [7:0]        buf_rd_data,
   output logic              ser_en,
   output logic              eng_req,
   output logic [2:0]        eng_cmd,
   output logic [7:0]        eng_tx_byte,
   output logic              eng_last,
   input  logic              eng_done,
   input  logic              eng_nack,
   input  logic              eng_fault,
   input  logic [7:0]        eng_rx_byte,
   output logic              done,
   output logic [1:0]        status
);

   localparam longint TO_CYC = longint'(CLK_HZ) * longint'(POLL_TIMEOUT_US) / 64'd1_000_000;

   if ((PAGE_SIZE < POL_BYTES) || ((PAGE_SIZE & (PAGE_SIZE - 1)) != 0)) begin : g_bad_page
      $error("PAGE_SIZE must be a power of two of at least 4");
   end
   if ((ADDR_W < 18) || (ADDR_W > 8 * ADDR_BYTES)) begin : g_bad_addr
      $error("ADDR_W must hold the polarity block and fit three address bytes");
   end
   if (TO_CYC < 1) begin : g_bad_timeout
      $error("poll timeout must be at least one clock");
   end

   phase_e           phase_q;
   op_e              op_q;
   logic [IDX_W-1:0] cnt_q;
   logic [ADDR_W-1:0] addr_q;
   logic             mism_q;
   logic             poll_ack_q;
   logic             ser_q;
   logic             done_q;
   status_e          status_q;

   logic             is_rd_op;
   logic             is_pol_op;
   logic [IDX_W-1:0] last_idx;
   logic             bad;
   logic             poll_run;
   logic             timer_expired;
   logic [7:0]       addr_byte;
   logic [1:0]       addr_sel;
   logic [7:0]       seq_rdata;
   logic             seq_we;
   logic             host_we;
   logic             accept;

   assign is_rd_op  = (op_q == OP_PAGE_RD) || (op_q == OP_POL_RD);
   assign is_pol_op = (op_q == OP_POL_WR) || (op_q == OP_POL_RD);
   assign last_idx  = is_pol_op ? IDX_W'(POL_BYTES - 1) : IDX_W'(PAGE_SIZE - 1);
   assign bad       = eng_nack | eng_fault;
   assign poll_run  = (phase_q == P_PSTART) || (phase_q == P_PADDR) || (phase_q == P_PSTOP);
   assign accept    = cmd_valid && (phase_q == P_IDLE);
   assign host_we   = buf_wr_en && (phase_q == P_IDLE);
   assign seq_we    = eng_done && !eng_fault && (phase_q == P_DATA) && (op_q == OP_PAGE_RD);
   assign addr_sel  = (phase_q == P_ADDR) ? cnt_q[1:0] : 2'd0;

   cfgprog_page_buf #(
      .DEPTH (PAGE_SIZE)
   ) u_buf (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_we    (host_we),
      .host_widx  (buf_wr_idx),
      .host_wdata (buf_wr_data),
      .seq_we     (seq_we),
      .seq_widx   (cnt_q),
      .seq_wdata  (eng_rx_byte),
      .host_ridx  (buf_rd_idx),
      .host_rdata (buf_rd_data),
      .seq_ridx   (cnt_q),
      .seq_rdata  (seq_rdata)
   );

   cfgprog_poll_timer #(
      .LIMIT (int'(TO_CYC))
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (poll_run),
      .expired (timer_expired)
   );

   cfgprog_addr_mux #(
      .ADDR_W (ADDR_W)
   ) u_addr (
      .addr   (addr_q),
      .sel    (addr_sel),
      .byte_o (addr_byte)
   );

   // command presented to the bus engine
   always_comb begin
      eng_cmd     = 3'(ENG_START);
      eng_tx_byte = 8'h00;
      eng_last    = 1'b0;
      unique case (phase_q)
         P_START, P_PSTART: eng_cmd = 3'(ENG_START);
         P_ADDR, P_PADDR: begin
            eng_cmd     = 3'(ENG_TX_MSB);
            eng_tx_byte = addr_byte;
         end
         P_DATA: begin
            if (is_rd_op) begin
               eng_cmd  = 3'(ENG_RX);
               eng_last = (cnt_q == last_idx);
            end else begin
               eng_cmd     = 3'(ENG_TX_LSB);
               eng_tx_byte = seq_rdata;
            end
         end
         P_STOP, P_PSTOP, P_ASTOP: eng_cmd = 3'(ENG_STOP);
         default: ;
      endcase
   end

   // sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q    <= P_IDLE;
         op_q       <= OP_PAGE_WR;
         cnt_q      <= '0;
         addr_q     <= '0;
         mism_q     <= 1'b0;
         poll_ack_q <= 1'b0;
         ser_q      <= 1'b0;
         done_q     <= 1'b0;
         status_q   <= ST_OK;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            op_q       <= op_e'(cmd_op);
            addr_q     <= (cmd_op[1]) ? POL_BASE[ADDR_W-1:0] : {cmd_page, {IDX_W{1'b0}}};
            cnt_q      <= '0;
            mism_q     <= 1'b0;
            poll_ack_q <= 1'b0;
            ser_q      <= 1'b1;
            phase_q    <= P_START;
         end else if (eng_done && phase_q != P_IDLE) begin
            unique case (phase_q)
               P_START: begin
                  cnt_q   <= '0;
                  phase_q <= bad ? P_ASTOP : P_ADDR;
               end
               P_ADDR: begin
                  if (bad) begin
                     phase_q <= P_ASTOP;
                  end else if (cnt_q == IDX_W'(ADDR_BYTES - 1)) begin
                     cnt_q   <= '0;
                     phase_q <= P_DATA;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               P_DATA: begin
                  if (bad) begin
                     phase_q <= P_ASTOP;
                  end else begin
                     if (op_q == OP_POL_RD && eng_rx_byte != seq_rdata) mism_q <= 1'b1;
                     if (cnt_q == last_idx) begin
                        cnt_q   <= '0;
                        phase_q <= P_STOP;
                     end else begin
                        cnt_q <= cnt_q + 1'b1;
                     end
                  end
               end
               P_STOP: begin
                  if (bad) begin
                     phase_q  <= P_IDLE;
                     ser_q    <= 1'b0;
                     done_q   <= 1'b1;
                     status_q <= ST_NACK;
                  end else if (!is_rd_op) begin
                     phase_q <= P_PSTART;
                  end else begin
                     phase_q  <= P_IDLE;
                     ser_q    <= 1'b0;
                     done_q   <= 1'b1;
                     status_q <= mism_q ? ST_MISMATCH : ST_OK;
                  end
               end
               P_PSTART: phase_q <= eng_fault ? P_ASTOP : P_PADDR;
               P_PADDR: begin
                  poll_ack_q <= !eng_nack;
                  phase_q    <= eng_fault ? P_ASTOP : P_PSTOP;
               end
               P_PSTOP: begin
                  if (eng_fault) begin
                     phase_q  <= P_IDLE;
                     ser_q    <= 1'b0;
                     done_q   <= 1'b1;
                     status_q <= ST_NACK;
                  end else if (poll_ack_q) begin
                     phase_q  <= P_IDLE;
                     ser_q    <= 1'b0;
                     done_q   <= 1'b1;
                     status_q <= ST_OK;
                  end else if (timer_expired) begin
                     phase_q  <= P_IDLE;
                     ser_q    <= 1'b0;
                     done_q   <= 1'b1;
                     status_q <= ST_TIMEOUT;
                  end else begin
                     phase_q <= P_PSTART;
                  end
               end
               P_ASTOP: begin
                  phase_q  <= P_IDLE;
                  ser_q    <= 1'b0;
                  done_q   <= 1'b1;
                  status_q <= ST_NACK;
               end
               default: phase_q <= P_IDLE;
            endcase
         end
      end
   end

   assign cmd_ready = (phase_q == P_IDLE);
   assign eng_req   = (phase_q != P_IDLE);
   assign ser_en    = ser_q;
   assign done      = done_q;
   assign status    = status_q;

   // R10
   eng_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_req && !eng_done) |=> (eng_req && $stable(eng_cmd) && $stable(eng_tx_byte) && $stable(eng_last)));

   // R12
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   done_follows_eng_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(eng_done));

   // R5
   last_on_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_last |-> (eng_cmd == 3'(ENG_RX)));

   // R4
   timeout_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && status == 2'(ST_TIMEOUT)) |-> $past(timer_expired));

   // R9
   ser_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_req |-> ser_en);

   // R9
   done_ser_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !ser_en);

endmodule

// File: tb/cfgmem_page_prog_tb.sv
`timescale 1ns/1ps
module cfgmem_page_prog_tb;

   localparam int PAGE_SIZE = 128;
   localparam int ADDR_W    = 18;
   localparam int IDX_W     = 7;
   localparam int PAGE_W    = ADDR_W - IDX_W;
   localparam int TO_CYC    = 500;
   localparam int LAT       = 2;
   localparam int LOG_MAX   = 1024;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cmd_valid = 1'b0;
   logic [1:0]        cmd_op = 2'd0;
   logic [PAGE_W-1:0] cmd_page = '0;
   logic              cmd_ready;
   logic              buf_wr_en = 1'b0;
   logic [IDX_W-1:0]  buf_wr_idx = '0;
   logic [7:0]        buf_wr_data = 8'h00;
   logic [IDX_W-1:0]  buf_rd_idx = '0;
   logic [7:0]        buf_rd_data;
   logic              ser_en;
   logic              eng_req;
   logic [2:0]        eng_cmd;
   logic [7:0]        eng_tx_byte;
   logic              eng_last;
   logic              eng_done = 1'b0;
   logic              eng_nack = 1'b0;
   logic              eng_fault = 1'b0;
   logic [7:0]        eng_rx_byte = 8'h00;
   logic              done;
   logic [1:0]        status;

   always #10 clk = ~clk;

   cfgmem_page_prog #(
      .PAGE_SIZE       (PAGE_SIZE),
      .ADDR_W          (ADDR_W),
      .CLK_HZ          (50_000_000),
      .POLL_TIMEOUT_US (10)
   ) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_valid   (cmd_valid),
      .cmd_op      (cmd_op),
      .cmd_page    (cmd_page),
      .cmd_ready   (cmd_ready),
      .buf_wr_en   (buf_wr_en),
      .buf_wr_idx  (buf_wr_idx),
      .buf_wr_data (buf_wr_data),
      .buf_rd_idx  (buf_rd_idx),
      .buf_rd_data (buf_rd_data),
      .ser_en      (ser_en),
      .eng_req     (eng_req),
      .eng_cmd     (eng_cmd),
      .eng_tx_byte (eng_tx_byte),
      .eng_last    (eng_last),
      .eng_done    (eng_done),
      .eng_nack    (eng_nack),
      .eng_fault   (eng_fault),
      .eng_rx_byte (eng_rx_byte),
      .done        (done),
      .status      (status)
   );

   int n_chk = 0;
   int n_fail = 0;

   // engine model state
   int         log_n = 0;
   logic [2:0] log_cmd  [LOG_MAX];
   logic [7:0] log_tx   [LOG_MAX];
   logic       log_last [LOG_MAX];
   logic       log_ser  [LOG_MAX];
   longint     log_dcyc [LOG_MAX];
   int         nack_at = -1;
   int         fault_at = -1;
   int         poll_nacks = 0;
   int         msb_seen = 0;
   int         rx_seen = 0;
   int         rx_mode = 0;
   logic [7:0] pol_rx [4];
   bit         pend = 0;
   int         wait_c = 0;
   int         cur_i = 0;
   bit         cur_nack = 0;
   bit         cur_fault = 0;
   logic [7:0] cur_rx = 8'h00;
   longint     cyc = 0;
   int         done_seen = 0;
   longint     done_cyc = 0;
   logic [1:0] last_status = 2'd0;

   always @(negedge clk) begin
      cyc = cyc + 1;
      if (done) done_seen = done_seen + 1;
      if (!rst_n) begin
         pend = 0;
         eng_done  <= 1'b0;
         eng_nack  <= 1'b0;
         eng_fault <= 1'b0;
      end else if (eng_done) begin
         eng_done  <= 1'b0;
         eng_nack  <= 1'b0;
         eng_fault <= 1'b0;
      end else if (pend) begin
         if (wait_c > 0) begin
            wait_c = wait_c - 1;
         end else begin
            pend = 0;
            eng_done    <= 1'b1;
            eng_nack    <= cur_nack;
            eng_fault   <= cur_fault;
            eng_rx_byte <= cur_rx;
            if (cur_i < LOG_MAX) log_dcyc[cur_i] = cyc;
         end
      end else if (eng_req) begin
         cur_i = log_n;
         if (log_n < LOG_MAX) begin
            log_cmd[log_n]  = eng_cmd;
            log_tx[log_n]   = eng_tx_byte;
            log_last[log_n] = eng_last;
            log_ser[log_n]  = ser_en;
         end
         log_n = log_n + 1;
         cur_nack  = (cur_i == nack_at);
         cur_fault = (cur_i == fault_at);
         cur_rx    = 8'h00;
         if (eng_cmd == 3'd2) begin
            if (msb_seen >= 3 && (msb_seen - 3) < poll_nacks) cur_nack = 1;
            msb_seen = msb_seen + 1;
         end
         if (eng_cmd == 3'd4) begin
            cur_rx = (rx_mode != 0) ? pol_rx[rx_seen % 4] : 8'(rx_seen * 7 + 3);
            rx_seen = rx_seen + 1;
         end
         pend = 1;
         wait_c = LAT;
      end
   end

   function automatic logic [7:0] fill_val(int i);
      return 8'(i * 13 + 5);
   endfunction

   task automatic check(input string req, input string what, input longint act, input longint exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic reset_model();
      log_n = 0;
      nack_at = -1;
      fault_at = -1;
      poll_nacks = 0;
      msb_seen = 0;
      rx_seen = 0;
      rx_mode = 0;
   endtask

   task automatic buf_write(input int idx, input logic [7:0] val);
      @(negedge clk);
      buf_wr_en   <= 1'b1;
      buf_wr_idx  <= IDX_W'(idx);
      buf_wr_data <= val;
      @(negedge clk);
      buf_wr_en   <= 1'b0;
   endtask

   task automatic buf_read(input int idx, output logic [7:0] val);
      buf_rd_idx = IDX_W'(idx);
      #1;
      val = buf_rd_data;
   endtask

   task automatic start_op(input int op, input int page);
      @(negedge clk);
      cmd_valid <= 1'b1;
      cmd_op    <= 2'(op);
      cmd_page  <= PAGE_W'(page);
      @(negedge clk);
      cmd_valid <= 1'b0;
   endtask

   task automatic wait_done(input string req);
      int k;
      k = 0;
      while (!done && k < 20000) begin
         @(negedge clk);
         k++;
      end
      check(req, "operation finished before watchdog", longint'(done), 1);
      done_cyc = cyc;
      last_status = status;
      check("R9", "ser_en low with done", longint'(ser_en), 0);
   endtask

   task automatic check_addr(input string req, input int base, input logic [23:0] a);
      int err;
      err = 0;
      for (int b = 0; b < 3; b++) begin
         if (log_cmd[base + b] !== 3'd2) err++;
         if (log_tx[base + b] !== a[8*(2-b) +: 8]) err++;
      end
      check(req, "three address bytes high first", err, 0);
   endtask

   task automatic check_ser_all(input string req);
      int err;
      err = 0;
      for (int i = 0; i < log_n && i < LOG_MAX; i++) if (log_ser[i] !== 1'b1) err++;
      check(req, "ser_en high on every request", err, 0);
   endtask

   task automatic test_reset();
      @(negedge clk);
      check("R1", "ser_en", longint'(ser_en), 0);
      check("R1", "eng_req", longint'(eng_req), 0);
      check("R1", "done", longint'(done), 0);
      check("R1", "cmd_ready", longint'(cmd_ready), 1);
      check("R1", "status", longint'(status), 0);
   endtask

   task automatic test_page_write();
      int err;
      reset_model();
      for (int i = 0; i < PAGE_SIZE; i++) buf_write(i, fill_val(i));
      poll_nacks = 3;
      start_op(0, 5);
      check("R9", "ser_en after accept", longint'(ser_en), 1);
      check("R11", "cmd_ready low while busy", longint'(cmd_ready), 0);
      wait_done("R2");
      check("R10", "one command per handshake, total", log_n, 1 + 3 + PAGE_SIZE + 1 + 4 * 3);
      check("R2", "start first", longint'(log_cmd[0]), 0);
      check_addr("R2", 1, 24'h000280);
      err = 0;
      for (int i = 0; i < PAGE_SIZE; i++) begin
         if (log_cmd[4 + i] !== 3'd3) err++;
         if (log_tx[4 + i] !== fill_val(i)) err++;
      end
      check("R2", "data bytes LSB-first in buffer order", err, 0);
      check("R2", "stop after data", longint'(log_cmd[4 + PAGE_SIZE]), 1);
      err = 0;
      for (int k = 0; k < 4; k++) begin
         if (log_cmd[133 + 3 * k] !== 3'd0) err++;
         if (log_cmd[134 + 3 * k] !== 3'd2 || log_tx[134 + 3 * k] !== 8'h00) err++;
         if (log_cmd[135 + 3 * k] !== 3'd1) err++;
      end
      check("R3", "poll attempts start/addr/stop", err, 0);
      check("R3", "status ok after ack", longint'(last_status), 0);
      check_ser_all("R9");
   endtask

   task automatic test_page_read();
      int err;
      int seen0;
      logic [7:0] v;
      reset_model();
      start_op(1, 11'h7FF);
      while (log_n < 20) @(negedge clk);
      buf_wr_en   <= 1'b1;
      buf_wr_idx  <= IDX_W'(10);
      buf_wr_data <= 8'hEE;
      cmd_valid   <= 1'b1;
      cmd_op      <= 2'd0;
      @(negedge clk);
      buf_wr_en   <= 1'b0;
      cmd_valid   <= 1'b0;
      wait_done("R5");
      check("R5", "command count", log_n, 1 + 3 + PAGE_SIZE + 1);
      check_addr("R5", 1, 24'h03FF80);
      err = 0;
      for (int i = 0; i < PAGE_SIZE; i++) begin
         if (log_cmd[4 + i] !== 3'd4) err++;
         if (log_last[4 + i] !== (i == PAGE_SIZE - 1)) err++;
      end
      check("R5", "receive commands and last flag", err, 0);
      check("R5", "stop at end", longint'(log_cmd[4 + PAGE_SIZE]), 1);
      check("R5", "status ok", longint'(last_status), 0);
      err = 0;
      for (int i = 0; i < PAGE_SIZE; i++) begin
         buf_read(i, v);
         if (v !== 8'(i * 7 + 3)) err++;
      end
      check("R5", "buffer holds received bytes", err, 0);
      buf_read(10, v);
      check("R11", "host write while busy ignored", longint'(v), longint'(8'(10 * 7 + 3)));
      seen0 = done_seen;
      repeat (30) @(negedge clk);
      check("R11", "command while busy ignored (no requests)", log_n, 1 + 3 + PAGE_SIZE + 1);
      check("R11", "command while busy ignored (no done)", done_seen, seen0);
      check("R12", "status held", longint'(status), 0);
   endtask

   task automatic test_timeout();
      longint elapsed;
      reset_model();
      poll_nacks = 1_000_000;
      start_op(0, 1);
      wait_done("R4");
      check("R4", "status timeout", longint'(last_status), 2);
      elapsed = done_cyc - log_dcyc[132];
      check("R4", "not before timeout", longint'(elapsed >= TO_CYC), 1);
      check("R4", "within one attempt after timeout", longint'(elapsed <= TO_CYC + 40), 1);
      check("R4", "last command is stop", longint'(log_cmd[log_n - 1]), 1);
   endtask

   task automatic test_pol_program();
      int err;
      reset_model();
      buf_write(0, 8'hA5);
      buf_write(1, 8'h5A);
      buf_write(2, 8'h3C);
      buf_write(3, 8'hC3);
      start_op(2, 0);
      wait_done("R6");
      check("R6", "command count", log_n, 1 + 3 + 4 + 1 + 3);
      check_addr("R6", 1, 24'h020000);
      err = 0;
      if (log_cmd[4] !== 3'd3 || log_tx[4] !== 8'hA5) err++;
      if (log_cmd[5] !== 3'd3 || log_tx[5] !== 8'h5A) err++;
      if (log_cmd[6] !== 3'd3 || log_tx[6] !== 8'h3C) err++;
      if (log_cmd[7] !== 3'd3 || log_tx[7] !== 8'hC3) err++;
      if (log_cmd[8] !== 3'd1) err++;
      if (log_cmd[9] !== 3'd0 || log_cmd[10] !== 3'd2 || log_tx[10] !== 8'h02 || log_cmd[11] !== 3'd1) err++;
      check("R6", "polarity bytes then one poll", err, 0);
      check("R6", "status ok", longint'(last_status), 0);
      check_ser_all("R9");
   endtask

   task automatic test_pol_verify(input bit corrupt);
      int err;
      logic [7:0] v;
      reset_model();
      rx_mode = 1;
      pol_rx[0] = 8'hA5;
      pol_rx[1] = 8'h5A;
      pol_rx[2] = corrupt ? 8'h3D : 8'h3C;
      pol_rx[3] = 8'hC3;
      start_op(3, 0);
      wait_done("R7");
      check("R7", "command count", log_n, 1 + 3 + 4 + 1);
      check_addr("R7", 1, 24'h020000);
      err = 0;
      for (int i = 0; i < 4; i++) begin
         if (log_cmd[4 + i] !== 3'd4) err++;
         if (log_last[4 + i] !== (i == 3)) err++;
      end
      check("R7", "four receives, last flagged", err, 0);
      check("R7", "verify status", longint'(last_status), corrupt ? 3 : 0);
      buf_read(2, v);
      check("R7", "buffer unchanged", longint'(v), longint'(8'h3C));
   endtask

   task automatic test_abort();
      reset_model();
      nack_at = 5;
      start_op(0, 2);
      wait_done("R8");
      check("R8", "stop right after nacked byte", log_n, 7);
      check("R8", "final command stop", longint'(log_cmd[6]), 1);
      check("R8", "status nack", longint'(last_status), 1);
      reset_model();
      fault_at = 0;
      start_op(1, 3);
      wait_done("R8");
      check("R8", "fault at start: start then stop", log_n, 2);
      check("R8", "fault at start: stop", longint'(log_cmd[1]), 1);
      check("R8", "fault status nack", longint'(last_status), 1);
      repeat (5) @(negedge clk);
      check("R12", "done single pulse", longint'(done), 0);
      check("R12", "status held", longint'(status), 1);
   endtask

   initial begin
      repeat (200_000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      test_reset();
      test_page_write();
      test_page_read();
      test_timeout();
      test_pol_program();
      test_pol_verify(1'b0);
      test_pol_verify(1'b1);
      test_abort();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule